// File: doc/BRIEF.md
# Self-Modifying Code Hazard Detector

This block keeps a cache of decoded instructions coherent with programs that rewrite their own code. It looks for the hazard from two directions.

On the data side, every store is presented as a probe. Its physical page is compared against all entries of an instruction-translation table. Each entry of that table carries a "code resident" flag, which means decoded operations from that page are currently cached. A store that lands on a flagged page clears the flag on every matching entry. One cycle later it raises an invalidate pulse that carries the page number.

On the fetch side, each new fetch address is compared at cache-line granularity against two groups of outstanding stores: the speculative store buffer and the committed write-combining buffer. A match with a speculative store asks the front end to re-fetch. A match with a committed store asks for a pipeline flush and a re-fetch together.

The translation walk, the decoded-instruction arrays and the store buffers are outside this block. They appear here only as fill, mark and address/valid inputs.

The store probe is a valid/ready stream. `st_ready` drops in any cycle in which a table fill is presented, because the fill owns the table that cycle. A store is taken only on `st_valid && st_ready`. A source that sees `st_ready` low must hold its store and offer it again. The fetch probe has no back-pressure: it is examined in every cycle in which `fetch_valid` is high. All response outputs are single-cycle pulses, registered one cycle after the probe that caused them.

Top module: `smc_hazard_detect`

## Requirements
- R1: While reset is asserted and after it is released, `inval_valid`, `refetch` and `flush` are low, and every table entry is invalid with its code-resident flag clear. A store offered right after reset therefore raises no invalidate.
- R2: A fill writes the page number into the indexed entry, marks the entry valid and clears its code-resident flag. A mark request to the same entry in the same cycle loses to the fill.
- R3: A mark request (`code_mark_valid`) sets the code-resident flag of the indexed entry only if that entry is valid. A mark on an invalid entry has no effect.
- R4: `st_ready` equals the inverse of `tlb_fill_valid`. A store offered while a fill is presented is not accepted, raises no invalidate and leaves every flag unchanged.
- R5: An accepted store whose page (address bits 31:12) equals the page of a valid entry with its flag set raises `inval_valid` for exactly the next cycle, with `inval_page` equal to that page.
- R6: A store that raises an invalidate clears the flag of every entry that matched it. A later store to the same page raises nothing until the page is marked again. A clear wins over a mark to the same entry in the same cycle.
- R7: A valid fetch whose line (address bits 31:6) equals the line of a valid speculative store-buffer entry, and of no valid committed entry, raises `refetch` with `flush` low in the next cycle.
- R8: A valid fetch whose line matches a valid committed write-combining entry raises both `flush` and `refetch` in the next cycle, whether or not a speculative entry also matches.
- R9: A fetch raises nothing if `fetch_valid` is low, if only the page matches but not the line, or if the matching buffer entries are not valid.
- R10: The fetch response is a pulse. A single-cycle fetch gives a single-cycle request, and the request drops in the cycle after the fetch is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_fill_valid | input | 1 | Write a translation entry this cycle |
| tlb_fill_idx | input | 7 | Entry written by the fill |
| tlb_fill_page | input | 20 | Physical page number for the filled entry |
| code_mark_valid | input | 1 | Decoded code from an entry's page was cached |
| code_mark_idx | input | 7 | Entry whose code-resident flag is set |
| st_valid | input | 1 | Store probe offered |
| st_ready | output | 1 | Store probe can be taken (low during a fill) |
| st_paddr | input | 32 | Physical address of the store |
| fetch_valid | input | 1 | Fetch probe present |
| fetch_addr | input | 32 | Physical fetch address |
| sb_valid | input | 8 | Valid bits of the speculative store-buffer entries |
| sb_addr | input | 256 | Addresses of those entries, entry i at bits 32*i+31:32*i |
| wc_valid | input | 4 | Valid bits of the committed write-combining entries |
| wc_addr | input | 128 | Addresses of those entries, entry i at bits 32*i+31:32*i |
| inval_valid | output | 1 | Pulse: a store modified a code-resident page |
| inval_page | output | 20 | Page to invalidate, meaningful with `inval_valid` |
| refetch | output | 1 | Pulse: fetch must be repeated |
| flush | output | 1 | Pulse: pipeline must be flushed |

## Verification
Wrong internal state in this block lives in the per-entry flags and page tags. If a flag is wrongly set, the next store to that page shows a spurious `inval_valid`. If a flag is wrongly cleared, or is never cleared, an invalidate goes missing or appears twice on back-to-back stores. These faults become visible one cycle after the first store probe that touches the entry, so the stimulus aims repeated stores at a small pool of pages. The fetch side holds no state beyond its response register. A wrong line compare or a wrong priority shows in `refetch`/`flush` on the very next cycle.

// File: rtl/smc_pkg.sv
package smc_pkg;
  // Outcome of one fetch probe, ordered by severity.
  typedef enum logic [1:0] {
    RSP_NONE    = 2'd0,
    RSP_REFETCH = 2'd1,
    RSP_FLUSH   = 2'd2
  } fetch_rsp_e;

  // Severity selection: a committed match outranks a speculative one.
  function automatic fetch_rsp_e pick_rsp(input logic probe, input logic spec_hit,
                                          input logic comm_hit);
    if (!probe)         return RSP_NONE;
    else if (comm_hit)  return RSP_FLUSH;
    else if (spec_hit)  return RSP_REFETCH;
    else                return RSP_NONE;
  endfunction
endpackage

// File: rtl/smc_itlb_tags.sv
module smc_itlb_tags #(
  parameter int ENTRIES = 128,
  parameter int PAGE_W  = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [IDX_W-1:0]  fill_idx,
  input  logic [PAGE_W-1:0] fill_page,
  input  logic              mark_valid,
  input  logic [IDX_W-1:0]  mark_idx,
  input  logic              lk_valid,
  input  logic [PAGE_W-1:0] lk_page,
  output logic              lk_hit
);
  logic [ENTRIES-1:0] ent_match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic              v_q;
    logic              res_q;
    logic [PAGE_W-1:0] page_q;
    logic              fill_me;
    logic              mark_me;

    assign fill_me      = fill_valid && (fill_idx == IDX_W'(g));
    assign mark_me      = mark_valid && (mark_idx == IDX_W'(g));
    assign ent_match[g] = v_q && res_q && (page_q == lk_page);

    // Priority per entry: fill, then store clear, then mark.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        res_q  <= 1'b0;
        page_q <= '0;
      end else if (fill_me) begin
        v_q    <= 1'b1;
        res_q  <= 1'b0;
        page_q <= fill_page;
      end else if (lk_valid && ent_match[g]) begin
        res_q  <= 1'b0;
      end else if (mark_me && v_q) begin
        res_q  <= 1'b1;
      end
    end
  end

  assign lk_hit = lk_valid && (|ent_match);
endmodule

// File: rtl/smc_buf_match.sv
module smc_buf_match #(
  parameter int N         = 8,
  parameter int PA_W      = 32,
  parameter int LINE_BITS = 6,
  localparam int LINE_W   = PA_W - LINE_BITS
) (
  input  logic              probe_valid,
  input  logic [LINE_W-1:0] probe_line,
  input  logic [N-1:0]      ent_valid,
  input  logic [N*PA_W-1:0] ent_addr,
  output logic              hit
);
  logic [N-1:0] ent_hit;
  logic         unused_offsets;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign ent_hit[g] = ent_valid[g] &&
                        (ent_addr[g*PA_W + LINE_BITS +: LINE_W] == probe_line);
  end

  assign unused_offsets = ^ent_addr;
  assign hit = probe_valid && (|ent_hit);
endmodule

// File: rtl/smc_fetch_resp.sv
module smc_fetch_resp
  import smc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic probe_valid,
  input  logic spec_hit,
  input  logic comm_hit,
  output logic refetch,
  output logic flush
);
  fetch_rsp_e rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= RSP_NONE;
    else        rsp_q <= pick_rsp(probe_valid, spec_hit, comm_hit);
  end

  assign flush   = (rsp_q == RSP_FLUSH);
  assign refetch = (rsp_q != RSP_NONE);
endmodule

// File: rtl/smc_hazard_detect.sv
module smc_hazard_detect #(
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12,
  parameter int LINE_BITS   = 6,
  parameter int TLB_ENTRIES = 128,
  parameter int SB_N        = 8,
  parameter int WC_N        = 4,
  localparam int PAGE_W     = PA_W - PAGE_BITS,
  localparam int LINE_W     = PA_W - LINE_BITS,
  localparam int TLB_IDX_W  = $clog2(TLB_ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tlb_fill_valid,
  input  logic [TLB_IDX_W-1:0] tlb_fill_idx,
  input  logic [PAGE_W-1:0]    tlb_fill_page,
  input  logic                 code_mark_valid,
  input  logic [TLB_IDX_W-1:0] code_mark_idx,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [PA_W-1:0]      st_paddr,
  input  logic                 fetch_valid,
  input  logic [PA_W-1:0]      fetch_addr,
  input  logic [SB_N-1:0]      sb_valid,
  input  logic [SB_N*PA_W-1:0] sb_addr,
  input  logic [WC_N-1:0]      wc_valid,
  input  logic [WC_N*PA_W-1:0] wc_addr,
  output logic                 inval_valid,
  output logic [PAGE_W-1:0]    inval_page,
  output logic                 refetch,
  output logic                 flush
);
  logic              st_fire;
  logic [PAGE_W-1:0] st_page;
  logic              code_hit;
  logic [LINE_W-1:0] fetch_line;
  logic              spec_hit;
  logic              comm_hit;
  logic              unused_low_bits;

  // A fill owns the translation table for its cycle; stores wait.
  assign st_ready   = !tlb_fill_valid;
  assign st_fire    = st_valid && st_ready;
  assign st_page    = st_paddr[PA_W-1:PAGE_BITS];
  assign fetch_line = fetch_addr[PA_W-1:LINE_BITS];
  assign unused_low_bits = ^{st_paddr[PAGE_BITS-1:0], fetch_addr[LINE_BITS-1:0]};

  smc_itlb_tags #(
    .ENTRIES (TLB_ENTRIES),
    .PAGE_W  (PAGE_W)
  ) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_valid (tlb_fill_valid),
    .fill_idx   (tlb_fill_idx),
    .fill_page  (tlb_fill_page),
    .mark_valid (code_mark_valid),
    .mark_idx   (code_mark_idx),
    .lk_valid   (st_fire),
    .lk_page    (st_page),
    .lk_hit     (code_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inval_valid <= 1'b0;
      inval_page  <= '0;
    end else begin
      inval_valid <= code_hit;
      if (code_hit) inval_page <= st_page;
    end
  end

  smc_buf_match #(
    .N         (SB_N),
    .PA_W      (PA_W),
    .LINE_BITS (LINE_BITS)
  ) u_spec (
    .probe_valid (fetch_valid),
    .probe_line  (fetch_line),
    .ent_valid   (sb_valid),
    .ent_addr    (sb_addr),
    .hit         (spec_hit)
  );

  smc_buf_match #(
    .N         (WC_N),
    .PA_W      (PA_W),
    .LINE_BITS (LINE_BITS)
  ) u_comm (
    .probe_valid (fetch_valid),
    .probe_line  (fetch_line),
    .ent_valid   (wc_valid),
    .ent_addr    (wc_addr),
    .hit         (comm_hit)
  );

  smc_fetch_resp u_resp (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_valid (fetch_valid),
    .spec_hit    (spec_hit),
    .comm_hit    (comm_hit),
    .refetch     (refetch),
    .flush       (flush)
  );
endmodule

// File: rtl/smc_hazard_chk.sv
module smc_hazard_chk (
  input logic clk,
  input logic rst_n,
  input logic tlb_fill_valid,
  input logic st_valid,
  input logic st_ready,
  input logic fetch_valid,
  input logic inval_valid,
  input logic refetch,
  input logic flush
);
  // R1: outputs are quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!inval_valid && !refetch && !flush);
    end
  end

  // R8: a flush always comes with a re-fetch
  a_r8_flush_with_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> refetch);

  // R9: no request without a fetch probe in the previous cycle
  a_r9_req_needs_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    refetch |-> $past(fetch_valid));

  // R5: an invalidate follows an accepted store
  a_r5_inval_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> $past(st_valid && st_ready));

  // R4: a store offered during a fill produces nothing
  a_r4_fill_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tlb_fill_valid) |-> !inval_valid);

  // R10: a request drops after the fetch probe goes away
  a_r10_pulse_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !refetch);
endmodule

bind smc_hazard_detect smc_hazard_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tlb_fill_valid (tlb_fill_valid),
  .st_valid       (st_valid),
  .st_ready       (st_ready),
  .fetch_valid    (fetch_valid),
  .inval_valid    (inval_valid),
  .refetch        (refetch),
  .flush          (flush)
);

// File: tb/sim_smc_hazard_detect.sv
`timescale 1ns/1ps
module sim_smc_hazard_detect;
  localparam int PA_W = 32;
  localparam int PAGE_W = 20;
  localparam int IDX_W = 7;
  localparam int ENT = 128;
  localparam int SB_N = 8;
  localparam int WC_N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              fill_v, use_v, st_v, f_v;
  logic [IDX_W-1:0]  fill_idx, use_idx;
  logic [PAGE_W-1:0] fill_pg;
  logic [PA_W-1:0]   st_addr, f_addr;
  logic [SB_N-1:0]   sbv;
  logic [WC_N-1:0]   wcv;
  logic [PA_W-1:0]   sba [SB_N];
  logic [PA_W-1:0]   wca [WC_N];
  logic [SB_N*PA_W-1:0] sb_flat;
  logic [WC_N*PA_W-1:0] wc_flat;
  logic st_ready, inval_valid, refetch, flush;
  logic [PAGE_W-1:0] inval_page;

  for (genvar i = 0; i < SB_N; i++) begin : g_sb
    assign sb_flat[i*PA_W +: PA_W] = sba[i];
  end
  for (genvar i = 0; i < WC_N; i++) begin : g_wc
    assign wc_flat[i*PA_W +: PA_W] = wca[i];
  end

  smc_hazard_detect u0 (
    .clk(clk), .rst_n(rst_n),
    .tlb_fill_valid(fill_v), .tlb_fill_idx(fill_idx), .tlb_fill_page(fill_pg),
    .code_mark_valid(use_v), .code_mark_idx(use_idx),
    .st_valid(st_v), .st_ready(st_ready), .st_paddr(st_addr),
    .fetch_valid(f_v), .fetch_addr(f_addr),
    .sb_valid(sbv), .sb_addr(sb_flat), .wc_valid(wcv), .wc_addr(wc_flat),
    .inval_valid(inval_valid), .inval_page(inval_page),
    .refetch(refetch), .flush(flush)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  logic [PAGE_W-1:0] m_page [ENT];
  bit m_v [ENT];
  bit m_use [ENT];
  bit e_inv, e_ref, e_fl;
  logic [PAGE_W-1:0] e_page;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit line_eq(input logic [PA_W-1:0] a, input logic [PA_W-1:0] b);
    return a[PA_W-1:6] == b[PA_W-1:6];
  endfunction

  // Called at a negedge with inputs applied; checks results at the next negedge.
  task automatic step(input string stag, input string ftag);
    bit acc, hit, sh, ch;
    logic [PAGE_W-1:0] sp;
    #1;
    chk(st_ready == !fill_v, "R4", "st_ready", st_ready, !fill_v);
    acc = st_v && !fill_v;
    sp = st_addr[PA_W-1:12];
    hit = 0;
    for (int i = 0; i < ENT; i++)
      if (m_v[i] && m_use[i] && m_page[i] == sp) hit = 1;
    hit = hit && acc;
    sh = 0; ch = 0;
    for (int i = 0; i < SB_N; i++) if (sbv[i] && line_eq(sba[i], f_addr)) sh = 1;
    for (int i = 0; i < WC_N; i++) if (wcv[i] && line_eq(wca[i], f_addr)) ch = 1;
    sh = sh && f_v;
    ch = ch && f_v;
    for (int i = 0; i < ENT; i++) begin
      if (fill_v && fill_idx == IDX_W'(i)) begin
        m_v[i] = 1; m_use[i] = 0; m_page[i] = fill_pg;
      end else if (hit && m_v[i] && m_use[i] && m_page[i] == sp) begin
        m_use[i] = 0;
      end else if (use_v && use_idx == IDX_W'(i) && m_v[i]) begin
        m_use[i] = 1;
      end
    end
    e_inv = hit; e_page = sp; e_ref = sh || ch; e_fl = ch;
    @(negedge clk);
    chk(inval_valid == e_inv, stag, "inval_valid", inval_valid, e_inv);
    if (e_inv) chk(inval_page == e_page, stag, "inval_page", inval_page, e_page);
    chk(refetch == e_ref, ftag, "refetch", refetch, e_ref);
    chk(flush == e_fl, ftag, "flush", flush, e_fl);
  endtask

  task automatic idle();
    fill_v = 0; use_v = 0; st_v = 0; f_v = 0;
    fill_idx = '0; use_idx = '0; fill_pg = '0; st_addr = '0; f_addr = '0;
  endtask

  task automatic clear_bufs();
    sbv = '0; wcv = '0;
    for (int i = 0; i < SB_N; i++) sba[i] = '0;
    for (int i = 0; i < WC_N; i++) wca[i] = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5a5a));
    for (int i = 0; i < ENT; i++) begin m_v[i] = 0; m_use[i] = 0; m_page[i] = '0; end
    idle();
    clear_bufs();
    repeat (3) @(negedge clk);
    chk(!inval_valid && !refetch && !flush, "R1", "outputs in reset",
        {inval_valid, refetch, flush}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: no entry is valid after reset
    st_v = 1; st_addr = 32'h0000_0010; step("R1", "R9");
    idle();

    // R5 then R6
    fill_v = 1; fill_idx = 5; fill_pg = 20'h00123; step("R2", "R9"); idle();
    use_v = 1; use_idx = 5; step("R3", "R9"); idle();
    st_v = 1; st_addr = 32'h0012_3456; step("R5", "R9"); idle();
    st_v = 1; st_addr = 32'h0012_3ffc; step("R6", "R9"); idle();

    // R3: mark on an invalid entry
    use_v = 1; use_idx = 9; step("R3", "R9"); idle();
    st_v = 1; st_addr = 32'h0000_0800; step("R3", "R9"); idle();

    // R2: fill beats mark on the same entry
    fill_v = 1; fill_idx = 7; fill_pg = 20'h00222; use_v = 1; use_idx = 7;
    step("R2", "R9"); idle();
    st_v = 1; st_addr = 32'h0022_2000; step("R2", "R9"); idle();

    // R4: store during fill is held off
    fill_v = 1; fill_idx = 20; fill_pg = 20'h00333; step("R2", "R9"); idle();
    use_v = 1; use_idx = 20; step("R3", "R9"); idle();
    fill_v = 1; fill_idx = 21; fill_pg = 20'h00444; st_v = 1; st_addr = 32'h0033_3100;
    step("R4", "R9"); idle();
    st_v = 1; st_addr = 32'h0033_3100; step("R4", "R9"); idle();

    // R6: clear wins over a mark in the same cycle
    use_v = 1; use_idx = 20; step("R3", "R9"); idle();
    st_v = 1; st_addr = 32'h0033_3200; use_v = 1; use_idx = 20; step("R6", "R9"); idle();
    st_v = 1; st_addr = 32'h0033_3300; step("R6", "R9"); idle();

    // Fetch side
    sbv[0] = 1; sba[0] = 32'h0030_0040;
    f_v = 1; f_addr = 32'h0030_007c; step("R9", "R7");
    wcv[2] = 1; wca[2] = 32'h0030_0044; step("R9", "R8");
    f_addr = 32'h0030_1040; step("R9", "R9");
    f_addr = 32'h0030_0040; sbv = '0; wcv = '0; step("R9", "R9");
    sbv[0] = 1; f_v = 0; step("R9", "R9");
    f_v = 1; step("R9", "R10");
    f_v = 0; step("R9", "R10");
    idle(); clear_bufs();

    // Random mix over a small pool of pages and lines
    for (int c = 0; c < 4000; c++) begin
      fill_v = ($urandom_range(0, 9) == 0);
      fill_idx = IDX_W'($urandom_range(0, 15));
      fill_pg = 20'h00100 + PAGE_W'($urandom_range(0, 7));
      use_v = ($urandom_range(0, 2) == 0);
      use_idx = IDX_W'($urandom_range(0, 15));
      st_v = ($urandom_range(0, 1) == 1);
      st_addr = {20'h00100 + PAGE_W'($urandom_range(0, 7)), 12'($urandom)};
      f_v = ($urandom_range(0, 4) != 0);
      f_addr = {($urandom_range(0, 7) == 0) ? 20'h00301 : 20'h00300,
                3'b000, 3'($urandom), 6'($urandom)};
      for (int i = 0; i < SB_N; i++) begin
        sbv[i] = ($urandom_range(0, 3) == 0);
        sba[i] = {20'h00300, 3'b000, 3'($urandom), 6'($urandom)};
      end
      for (int i = 0; i < WC_N; i++) begin
        wcv[i] = ($urandom_range(0, 5) == 0);
        wca[i] = {20'h00300, 3'b000, 3'($urandom), 6'($urandom)};
      end
      step("R5 R6", "R7 R8");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule